// File: doc/BRIEF.md
# Dual-Channel DRAM Ring Buffer Pointer Controller

This block keeps two independent ring pointers, one for a host channel and one for a DMA channel, over an external DRAM that is carved into equal-sized buffers. Each pointer picks the current buffer. The block turns it into a DRAM start address from the programmed buffer size and the configured bus width. Each channel also has a byte counter. When that counter runs out, the channel's pointer moves on to the next buffer, and it wraps to buffer 0 after the last buffer that fits in the installed DRAM. The block tracks no buffer occupancy, so software must keep the two channels from overrunning each other.

The host counter is reloaded from a 16-bit block limit on every address-write event. If the limit-enable bit is set, it emits a one-cycle event when it runs out. The DMA counter is loaded from a retained 16-bit length on each rising edge of the DMA enable. When it runs out, it raises a done flag that stays set until the enable is dropped. Raising the enable again starts another transfer of the same length. A small register port gives software write and read access to the pointers, the limits and the configuration.

Top module: `dram_ring_ptr_ctrl`

## Requirements
- R1: After reset, every register reads 0, both pointers are 0, both DRAM addresses are 0, and host_max_evt and dma_done are low.
- R2: Register addresses: 0 configuration, 1 host pointer, 2 DMA pointer, 3 and 4 host limit low and high byte, 5 and 6 DMA length low and high byte. A write lands on the clock edge and reads back unchanged. Address 7 ignores writes and reads 0. Configuration bits: bit 0 selects a 16-bit bus, bit 1 enables the host limit, bits 4:2 hold the buffer-size code b, and bits 7:5 hold the DRAM-size code m.
- R3: Each DRAM address equals (pointer × 2^(6+b)) for an 8-bit bus, and that value shifted right by one for a 16-bit bus. It follows the pointer and the configuration without delay.
- R4: The last usable buffer index is 2^(10+m−b)−1, capped at 255. A buffer holds 64·2^b bytes and the DRAM holds 64 KiB·2^m.
- R5: A host address-write loads the host counter from the 16-bit host limit. Each host byte strobe lowers the counter by one, and the counter stays at 0 once it gets there.
- R6: With the limit enabled, the host byte that takes the counter from 1 to 0 advances the host pointer on that edge. It also raises host_max_evt for exactly the following cycle.
- R7: With the limit disabled, the host counter still counts down, but host_max_evt stays low and the host pointer does not move.
- R8: An advance from a pointer at or above the last usable index gives 0.
- R9: A rising DMA enable loads the DMA counter from the DMA length. The byte that takes the counter to 0 sets dma_done and advances the DMA pointer. dma_done holds while the enable is high, and later DMA bytes have no effect. Dropping the enable clears dma_done on the next edge.
- R10: Dropping and raising the DMA enable again runs another transfer of the same length, and the length registers keep their values.
- R11: A register write to a pointer in the same cycle as that pointer's advance takes priority: the written value is kept.
- R12: A host address-write in the same cycle as a host byte reloads the counter and ignores the byte. A DMA byte in the cycle the enable rises is ignored.
- R13: A counter loaded with 0 never produces host_max_evt or dma_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| host_addr_wr | input | 1 | Host address-write event, reloads the host counter |
| host_byte | input | 1 | One host byte transferred |
| dma_en | input | 1 | DMA enable level |
| dma_byte | input | 1 | One DMA byte transferred |
| host_dram_addr | output | ADDR_W | DRAM start address of the current host buffer |
| dma_dram_addr | output | ADDR_W | DRAM start address of the current DMA buffer |
| host_max_evt | output | 1 | One-cycle host limit event |
| dma_done | output | 1 | DMA transfer complete, held until the enable drops |

## Verification
Two collisions in the same cycle matter most. The first is a software write to a pointer in the same cycle as the counter-driven advance of that pointer. The bench provokes it by timing the write strobe onto the byte that empties a counter loaded with 1. It passes only if the written value, not the incremented one, comes back. The second is a counter reload in the same cycle as a byte strobe, either an address-write or the DMA enable edge. Here the bench counts how many more bytes it takes to reach the event: one byte too few shows that the byte was wrongly counted.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int REG_W = 8;
    localparam int PTR_W = 8;
    localparam int RA_W  = 3;

    typedef struct packed {
        logic [2:0] dram_code;
        logic [2:0] buf_code;
        logic       lim_en;
        logic       bus16;
    } cfg_t;

    typedef enum logic [RA_W-1:0] {
        RA_CFG     = 3'd0,
        RA_HPTR    = 3'd1,
        RA_DPTR    = 3'd2,
        RA_HLIM_LO = 3'd3,
        RA_HLIM_HI = 3'd4,
        RA_DLEN_LO = 3'd5,
        RA_DLEN_HI = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;

    // highest usable buffer index for a configuration
    function automatic logic [PTR_W-1:0] last_index(input cfg_t c,
                                                    input int buf_base_log,
                                                    input int dram_base_log);
        int lg;
        lg = dram_base_log + int'(c.dram_code) - buf_base_log - int'(c.buf_code);
        if (lg >= PTR_W)
            return '1;
        else if (lg <= 0)
            return '0;
        else
            return PTR_W'((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/rp_regs.sv
module rp_regs
    import ring_ptr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RA_W-1:0]  addr,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] host_limit,
    output logic [CNT_W-1:0] dma_length
);

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] hlim;
        logic [CNT_W-1:0] dlen;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                RA_CFG:     regs_d.cfg = cfg_t'(wdata);
                RA_HLIM_LO: regs_d.hlim[REG_W-1:0] = wdata;
                RA_HLIM_HI: regs_d.hlim[CNT_W-1:REG_W] = wdata[CNT_W-REG_W-1:0];
                RA_DLEN_LO: regs_d.dlen[REG_W-1:0] = wdata;
                RA_DLEN_HI: regs_d.dlen[CNT_W-1:REG_W] = wdata[CNT_W-REG_W-1:0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg        = regs_q.cfg;
    assign host_limit = regs_q.hlim;
    assign dma_length = regs_q.dlen;

    // R2: configuration only changes through a write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg));

    // R10: DMA length survives anything but a write to its own bytes
    p_len_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == RA_DLEN_LO || addr == RA_DLEN_HI)) |=> $stable(dma_length));

endmodule

// File: rtl/rp_byte_counter.sv
module rp_byte_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cnt_en,
    input  logic             byte_stb,
    input  logic             evt_en,
    output logic             hit,
    output logic             evt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             evt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        hit      = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (cnt_en && byte_stb && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1) && evt_en) begin
                hit      = 1'b1;
                st_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;

    // R6: the event never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R5: an empty counter stays empty until reloaded
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !load) |=> st_q.cnt == '0);

    // R13: an event always follows a count of one
    p_evt_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |=> !evt);

endmodule

// File: rtl/rp_ring_ptr.sv
module rp_ring_ptr
    import ring_ptr_pkg::*;
#(
    parameter int BUF_BASE_LOG = 6,
    parameter int ADDR_W       = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PTR_W-1:0]  wdata,
    input  logic              incr,
    input  logic [PTR_W-1:0]  last_idx,
    input  logic [2:0]        buf_code,
    input  logic              bus16,
    output logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);

    logic [PTR_W-1:0]  ptr_d, ptr_q;
    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        ptr_d = ptr_q;
        if (wr)
            ptr_d = wdata;
        else if (incr)
            ptr_d = (ptr_q >= last_idx) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        byte_addr = ADDR_W'(ptr_q) << (BUF_BASE_LOG + int'(buf_code));
        addr      = bus16 ? (byte_addr >> 1) : byte_addr;
    end

    assign ptr = ptr_q;

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !wr && ptr_q >= last_idx) |=> ptr_q == '0);

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !wr && ptr_q < last_idx) |=> ptr_q == $past(ptr_q) + 1'b1);

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ptr_q == $past(wdata));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !incr) |=> $stable(ptr_q));

endmodule

// File: rtl/dram_ring_ptr_ctrl.sv
module dram_ring_ptr_ctrl
    import ring_ptr_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int BUF_BASE_LOG  = 6,
    parameter int DRAM_BASE_LOG = 16,
    parameter int ADDR_W        = DRAM_BASE_LOG + 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              host_addr_wr,
    input  logic              host_byte,
    input  logic              dma_en,
    input  logic              dma_byte,
    output logic [ADDR_W-1:0] host_dram_addr,
    output logic [ADDR_W-1:0] dma_dram_addr,
    output logic              host_max_evt,
    output logic              dma_done
);

    typedef struct packed {
        logic en;
        logic done;
    } dma_st_t;

    cfg_t             cfg;
    logic [CNT_W-1:0] host_limit, dma_length;
    logic [PTR_W-1:0] last_idx, host_ptr, dma_ptr;
    logic             host_hit, dma_hit, dma_evt_unused;
    logic             dma_rise, dma_cnt_en;
    logic             host_ptr_wr, dma_ptr_wr;
    dma_st_t          dma_d, dma_q;

    rp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .cfg        (cfg),
        .host_limit (host_limit),
        .dma_length (dma_length)
    );

    assign last_idx    = last_index(cfg, BUF_BASE_LOG, DRAM_BASE_LOG);
    assign host_ptr_wr = reg_wr && (reg_addr == RA_HPTR);
    assign dma_ptr_wr  = reg_wr && (reg_addr == RA_DPTR);

    rp_byte_counter #(.CNT_W(CNT_W)) u_host_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (host_addr_wr),
        .load_val (host_limit),
        .cnt_en   (1'b1),
        .byte_stb (host_byte),
        .evt_en   (cfg.lim_en),
        .hit      (host_hit),
        .evt      (host_max_evt)
    );

    always_comb begin
        dma_d      = dma_q;
        dma_d.en   = dma_en;
        dma_rise   = dma_en && !dma_q.en;
        dma_cnt_en = dma_en && !dma_q.done;
        if (!dma_en)
            dma_d.done = 1'b0;
        else if (dma_hit)
            dma_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= dma_d;
    end

    assign dma_done = dma_q.done;

    rp_byte_counter #(.CNT_W(CNT_W)) u_dma_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dma_rise),
        .load_val (dma_length),
        .cnt_en   (dma_cnt_en),
        .byte_stb (dma_byte),
        .evt_en   (1'b1),
        .hit      (dma_hit),
        .evt      (dma_evt_unused)
    );

    rp_ring_ptr #(.BUF_BASE_LOG(BUF_BASE_LOG), .ADDR_W(ADDR_W)) u_host_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_ptr_wr),
        .wdata    (reg_wdata),
        .incr     (host_hit),
        .last_idx (last_idx),
        .buf_code (cfg.buf_code),
        .bus16    (cfg.bus16),
        .ptr      (host_ptr),
        .addr     (host_dram_addr)
    );

    rp_ring_ptr #(.BUF_BASE_LOG(BUF_BASE_LOG), .ADDR_W(ADDR_W)) u_dma_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dma_ptr_wr),
        .wdata    (reg_wdata),
        .incr     (dma_hit),
        .last_idx (last_idx),
        .buf_code (cfg.buf_code),
        .bus16    (cfg.bus16),
        .ptr      (dma_ptr),
        .addr     (dma_dram_addr)
    );

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            RA_CFG:     reg_rdata = REG_W'(cfg);
            RA_HPTR:    reg_rdata = host_ptr;
            RA_DPTR:    reg_rdata = dma_ptr;
            RA_HLIM_LO: reg_rdata = host_limit[REG_W-1:0];
            RA_HLIM_HI: reg_rdata = REG_W'(host_limit >> REG_W);
            RA_DLEN_LO: reg_rdata = dma_length[REG_W-1:0];
            RA_DLEN_HI: reg_rdata = REG_W'(dma_length >> REG_W);
            default:    reg_rdata = '0;
        endcase
    end

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && dma_en) |=> dma_done);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !dma_done);

    p_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && dma_en && !dma_ptr_wr) |=> $stable(dma_ptr));

    p_rise_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !dma_q.en) |=> !dma_done);

endmodule

// File: tb/dram_ring_ptr_ctrl_test.sv
`timescale 1ns/1ps
module dram_ring_ptr_ctrl_test;

    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          host_addr_wr = 1'b0;
    logic          host_byte = 1'b0;
    logic          dma_en = 1'b0;
    logic          dma_byte = 1'b0;
    logic [AW-1:0] host_dram_addr, dma_dram_addr;
    logic          host_max_evt, dma_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_ring_ptr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_addr_wr(host_addr_wr), .host_byte(host_byte),
        .dma_en(dma_en), .dma_byte(dma_byte),
        .host_dram_addr(host_dram_addr), .dma_dram_addr(dma_dram_addr),
        .host_max_evt(host_max_evt), .dma_done(dma_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] cfg_byte(input int m, input int b, input bit lim, input bit b16);
        return {m[2:0], b[2:0], lim, b16};
    endfunction

    task automatic dma_run(input int nbytes);
        dma_en = 1'b1; tick();
        for (int i = 0; i < nbytes; i++) begin
            dma_byte = 1'b1; tick(); dma_byte = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] rd;
        logic [31:0] exp_a;
        int last;

        repeat (3) tick();
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd_reg(a[2:0], rd);
            chk("R1 reg reset", rd, 0);
        end
        chk("R1 host addr", host_dram_addr, 0);
        chk("R1 dma addr", dma_dram_addr, 0);
        chk("R1 evt", host_max_evt, 0);
        chk("R1 done", dma_done, 0);
        rst_n = 1'b1;
        tick();

        // R2: map readback
        for (int a = 0; a < 8; a++) wr_reg(a[2:0], 8'h11 * (a + 1));
        for (int a = 0; a < 7; a++) begin
            rd_reg(a[2:0], rd);
            chk("R2 readback", rd, 8'h11 * (a + 1));
        end
        rd_reg(3'd7, rd);
        chk("R2 spare reads 0", rd, 0);
        rd_reg(3'd0, rd);
        chk("R2 cfg bits", rd, 8'h11);

        // R3: address sweep, all buffer codes, both bus widths, every pointer
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 8; b++) begin
                wr_reg(3'd0, cfg_byte(7, b, 1'b0, w[0]));
                for (int p = 0; p < 256; p++) begin
                    wr_reg(3'd1, p[7:0]);
                    wr_reg(3'd2, p[7:0] ^ 8'h5a);
                    exp_a = (32'(p) << (6 + b)) >> w;
                    chk("R3 host addr", host_dram_addr, exp_a);
                    exp_a = (32'(p ^ 8'h5a) << (6 + b)) >> w;
                    chk("R3 dma addr", dma_dram_addr, exp_a);
                end
            end
        end

        // R4 / R8: capacity sweep through the DMA channel
        wr_reg(3'd5, 8'd1);
        wr_reg(3'd6, 8'd0);
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 8; b++) begin
                last = (10 + m - b >= 8) ? 255 : (1 << (10 + m - b)) - 1;
                wr_reg(3'd0, cfg_byte(m, b, 1'b0, 1'b0));
                wr_reg(3'd2, 8'(last));
                dma_run(1);
                rd_reg(3'd2, rd);
                chk("R8 wrap at last", rd, 0);
                chk("R9 done", dma_done, 1);
                dma_en = 1'b0; tick();
                wr_reg(3'd2, 8'(last - 1));
                dma_run(1);
                rd_reg(3'd2, rd);
                chk("R4 reach last", rd, 32'(last));
                dma_en = 1'b0; tick();
            end
        end
        // R8: out-of-range pointer (last = 7)
        wr_reg(3'd0, cfg_byte(0, 7, 1'b0, 1'b0));
        wr_reg(3'd2, 8'd200);
        dma_run(1);
        rd_reg(3'd2, rd);
        chk("R8 above last", rd, 0);
        dma_en = 1'b0; tick();

        // R5 / R6: host limit 5
        wr_reg(3'd0, cfg_byte(7, 0, 1'b1, 1'b0));
        wr_reg(3'd3, 8'd5); wr_reg(3'd4, 8'd0);
        wr_reg(3'd1, 8'd3);
        host_addr_wr = 1'b1; tick(); host_addr_wr = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            host_byte = 1'b1; tick(); host_byte = 1'b0;
            chk("R6 evt timing", host_max_evt, (i == 5));
            tick();
            chk("R6 evt one cycle", host_max_evt, 0);
        end
        rd_reg(3'd1, rd);
        chk("R6 host ptr advanced", rd, 4);
        chk("R6 host addr", host_dram_addr, 4 << 6);
        host_byte = 1'b1; repeat (3) tick(); host_byte = 1'b0;
        rd_reg(3'd1, rd);
        chk("R5 stays at zero", rd, 4);
        chk("R5 no evt at zero", host_max_evt, 0);

        // R5: 16-bit limit 0x0103, continuous strobes
        wr_reg(3'd3, 8'h03); wr_reg(3'd4, 8'h01);
        host_addr_wr = 1'b1; tick(); host_addr_wr = 1'b0;
        host_byte = 1'b1;
        for (int i = 1; i <= 259; i++) begin
            tick();
            if (i == 258 || i == 259) chk("R5 wide limit", host_max_evt, (i == 259));
            else if (host_max_evt) chk("R5 early evt", 1, 0);
        end
        host_byte = 1'b0; tick();
        rd_reg(3'd1, rd);
        chk("R5 wide ptr", rd, 5);

        // R7: limit disabled
        wr_reg(3'd0, cfg_byte(7, 0, 1'b0, 1'b0));
        wr_reg(3'd3, 8'd2); wr_reg(3'd4, 8'd0);
        host_addr_wr = 1'b1; tick(); host_addr_wr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            host_byte = 1'b1; tick(); host_byte = 1'b0;
            chk("R7 no evt", host_max_evt, 0);
        end
        rd_reg(3'd1, rd);
        chk("R7 ptr still", rd, 5);

        // R13: zero limit / zero length
        wr_reg(3'd0, cfg_byte(7, 0, 1'b1, 1'b0));
        wr_reg(3'd3, 8'd0);
        host_addr_wr = 1'b1; tick(); host_addr_wr = 1'b0;
        host_byte = 1'b1; tick(); tick(); host_byte = 1'b0;
        chk("R13 host zero", host_max_evt, 0);
        wr_reg(3'd5, 8'd0);
        dma_run(3);
        chk("R13 dma zero", dma_done, 0);
        dma_en = 1'b0; tick();

        // R11: pointer write collides with advance
        wr_reg(3'd3, 8'd1);
        host_addr_wr = 1'b1; tick(); host_addr_wr = 1'b0;
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h20; host_byte = 1'b1;
        tick();
        reg_wr = 1'b0; host_byte = 1'b0;
        rd_reg(3'd1, rd);
        chk("R11 host write wins", rd, 8'h20);
        wr_reg(3'd5, 8'd1);
        dma_en = 1'b1; tick();
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h33; dma_byte = 1'b1;
        tick();
        reg_wr = 1'b0; dma_byte = 1'b0;
        rd_reg(3'd2, rd);
        chk("R11 dma write wins", rd, 8'h33);
        chk("R11 dma done", dma_done, 1);
        dma_en = 1'b0; tick();

        // R12: reload beats byte
        wr_reg(3'd3, 8'd2);
        host_addr_wr = 1'b1; host_byte = 1'b1; tick(); host_addr_wr = 1'b0; host_byte = 1'b0;
        host_byte = 1'b1; tick(); host_byte = 1'b0;
        chk("R12 host byte ignored", host_max_evt, 0);
        host_byte = 1'b1; tick(); host_byte = 1'b0;
        chk("R12 host evt", host_max_evt, 1);
        wr_reg(3'd2, 8'd0);
        dma_en = 1'b1; dma_byte = 1'b1; tick(); dma_byte = 1'b0;
        chk("R12 dma edge byte ignored", dma_done, 0);
        dma_byte = 1'b1; tick(); dma_byte = 1'b0;
        chk("R12 dma done after byte", dma_done, 1);

        // R9: bytes after done ignored, done holds, clears on disable
        dma_byte = 1'b1; tick(); tick(); dma_byte = 1'b0;
        rd_reg(3'd2, rd);
        chk("R9 ptr frozen after done", rd, 1);
        chk("R9 done held", dma_done, 1);
        dma_en = 1'b0; tick();
        chk("R9 done cleared", dma_done, 0);

        // R10: repeat with the same length 3
        wr_reg(3'd5, 8'd3);
        for (int r = 0; r < 2; r++) begin
            dma_run(2);
            chk("R10 not yet done", dma_done, 0);
            dma_byte = 1'b1; tick(); dma_byte = 1'b0;
            chk("R10 done", dma_done, 1);
            dma_en = 1'b0; tick();
        end
        rd_reg(3'd2, rd);
        chk("R10 ptr two advances", rd, 3);
        rd_reg(3'd5, rd);
        chk("R10 length kept", rd, 3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule